// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned W-bit operands and returns the full 2W-bit product. A small control state machine drives a three-register datapath. The first register holds the multiplicand, widened to 2W bits, and shifts left. The second holds the multiplier at W bits and shifts right. The third is a 2W-bit accumulator that takes either its sum with the multiplicand or zero.

Each iteration is split into two cycles. In the first, a decision state looks at the multiplier register. In the second, a shift step or a shift-and-accumulate step runs. The loop stops as soon as the multiplier register is empty, so small multipliers finish sooner than large ones.

A caller sets the operands and raises `start` while the block is idle. It then waits for `done` and reads `product` while `done` stays high. Lowering `start` returns the block to idle, so each start request gives exactly one result.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes idle and clears all three registers. After that edge, `done` is 0 and `product` is 0.
- R2: While idle, the block reloads both operands on every cycle and holds the accumulator at zero. `product` reads 0 and `done` reads 0.
- R3: `start` sampled high while idle begins a computation. Every shift step and every shift-and-accumulate step is followed by a decision cycle.
- R4: When `done` is high, `product` equals the unsigned product of the X and Y sampled at the start edge, with all 2W bits.
- R5: Let k be the index of the highest set bit of Y. `done` is first seen high 2*(k+1)+2 cycles after the start edge. If Y is 0, this takes 2 cycles.
- R6: For X=9 and Y=5, `done` rises 8 cycles after the start edge and `product` is 45.
- R7: While `done` is high and `start` stays high, `done` remains high and `product` holds its value. One cycle after `start` is low in that state, `done` is 0. Another result needs a new start request.
- R8: Changes to `x_in` or `y_in` after the start edge have no effect on the product being computed.
- R9: An operand of zero on either side gives a product of 0. All-ones operands give (2^W-1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiply when idle; hold high to keep the result |
| x_in | input | W | Multiplicand operand |
| y_in | input | W | Multiplier operand |
| product | output | 2W | Accumulated product |
| done | output | 1 | Result valid |

## Verification
The assertions check four things on every cycle. After each step, the sum of the accumulator and the multiplicand times the multiplier is left unchanged. Loads clear the accumulator and capture the operands. Every step returns to the decision state. A finished result stays stable while `start` is held. The bench scenarios are the only way to show the other properties: the end-to-end product value, the data-dependent latency for each top bit position, the single-result handshake, and the fact that operand changes during a run have no effect.

// File: rtl/mul_pkg.sv
package mul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DECIDE = 3'd1,
        ST_SHIFT  = 3'd2,
        ST_SHADD  = 3'd3,
        ST_FIN    = 3'd4
    } mul_state_e;

    typedef struct packed {
        logic ld_a;
        logic sh_a;
        logic ld_b;
        logic sh_b;
        logic add_sel;
        logic ld_p;
        logic done;
    } mul_ctl_t;

    localparam mul_ctl_t CTL_NONE = '0;

    function automatic mul_ctl_t ctl_for(mul_state_e s);
        mul_ctl_t c;
        c = CTL_NONE;
        case (s)
            ST_IDLE: begin
                c.ld_a = 1'b1;
                c.ld_b = 1'b1;
                c.ld_p = 1'b1;
            end
            ST_SHIFT: begin
                c.sh_a = 1'b1;
                c.sh_b = 1'b1;
            end
            ST_SHADD: begin
                c.sh_a    = 1'b1;
                c.sh_b    = 1'b1;
                c.ld_p    = 1'b1;
                c.add_sel = 1'b1;
            end
            ST_FIN:  c.done = 1'b1;
            default: c = CTL_NONE;
        endcase
        return c;
    endfunction

    function automatic mul_state_e next_for(mul_state_e s, logic go,
                                            logic b_zero, logic b_lsb);
        mul_state_e n;
        case (s)
            ST_IDLE:   n = go ? ST_DECIDE : ST_IDLE;
            ST_DECIDE: n = b_zero ? ST_FIN : (b_lsb ? ST_SHADD : ST_SHIFT);
            ST_SHIFT:  n = ST_DECIDE;
            ST_SHADD:  n = ST_DECIDE;
            ST_FIN:    n = go ? ST_FIN : ST_IDLE;
            default:   n = ST_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     b_zero,
    input  logic     b_lsb,
    output mul_ctl_t ctl
);

    mul_state_e state_q;
    mul_state_e state_d;

    always_comb begin
        state_d = next_for(state_q, start, b_zero, b_lsb);
        ctl     = ctl_for(state_q);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R1: reset forces the idle state
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE));

    // R3: every step is followed by a decision cycle
    a_r3_step_to_decide: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT || state_q == ST_SHADD) |=> (state_q == ST_DECIDE));

    // R5: an empty multiplier at a decision ends the run
    a_r5_zero_finishes: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DECIDE && b_zero) |=> ctl.done);

    // R7: the result flag holds while start stays high
    a_r7_done_hold: assert property (@(posedge clk) disable iff (rst)
        (ctl.done && start) |=> ctl.done);

    // R7: the result flag drops once start is low
    a_r7_done_release: assert property (@(posedge clk) disable iff (rst)
        (ctl.done && !start) |=> !ctl.done);

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
    import mul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  x_i,
    input  logic [W-1:0]  y_i,
    input  mul_ctl_t      ctl,
    output logic          b_zero,
    output logic          b_lsb,
    output logic [2*W-1:0] p_o
);

    localparam int PW = 2 * W;

    logic [PW-1:0] a_q;
    logic [W-1:0]  b_q;
    logic [PW-1:0] p_q;
    logic [PW-1:0] p_next;

    // adder-or-zero unit in front of the accumulator
    always_comb begin
        p_next = ctl.add_sel ? (p_q + a_q) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
        end else if (ctl.ld_a) begin
            a_q <= {{W{1'b0}}, x_i};
        end else if (ctl.sh_a) begin
            a_q <= a_q << 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else if (ctl.ld_b) begin
            b_q <= y_i;
        end else if (ctl.sh_b) begin
            b_q <= b_q >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '0;
        end else if (ctl.ld_p) begin
            p_q <= p_next;
        end
    end

    assign b_zero = (b_q == '0);
    assign b_lsb  = b_q[0];
    assign p_o    = p_q;

    logic [PW-1:0] invariant_w;
    assign invariant_w = p_q + a_q * {{W{1'b0}}, b_q};

    // R4: each step keeps P + A*B unchanged
    a_r4_step_invariant: assert property (@(posedge clk) disable iff (rst)
        (ctl.sh_a && ctl.sh_b) |=> (invariant_w == $past(invariant_w)));

    // R2: idle load captures operands and clears the accumulator
    a_r2_idle_load: assert property (@(posedge clk) disable iff (rst)
        (ctl.ld_a && ctl.ld_b && ctl.ld_p && !ctl.add_sel) |=>
        (p_q == '0 && b_q == $past(y_i) && a_q == {{W{1'b0}}, $past(x_i)}));

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
    import mul_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   x_in,
    input  logic [W-1:0]   y_in,
    output logic [2*W-1:0] product,
    output logic           done
);

    mul_ctl_t ctl;
    logic     b_zero;
    logic     b_lsb;

    mul_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .b_zero (b_zero),
        .b_lsb  (b_lsb),
        .ctl    (ctl)
    );

    mul_datapath #(.W(W)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .x_i    (x_in),
        .y_i    (y_in),
        .ctl    (ctl),
        .b_zero (b_zero),
        .b_lsb  (b_lsb),
        .p_o    (product)
    );

    assign done = ctl.done;

    // R7: a finished product is stable while the flag stays high
    a_r7_product_stable: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> $stable(product));

endmodule

// File: tb/sim_shift_add_mult.sv
module sim_shift_add_mult;

    localparam int W  = 8;
    localparam int PW = 2 * W;
    localparam int NV = 16;

    localparam logic [2*W-1:0] VEC [NV] = '{
        {8'd9,   8'd5},   {8'd0,   8'd0},   {8'd0,   8'd255}, {8'd255, 8'd0},
        {8'd1,   8'd1},   {8'd255, 8'd255}, {8'd1,   8'd255}, {8'd255, 8'd1},
        {8'd37,  8'd128}, {8'd200, 8'd64},  {8'd13,  8'd2},   {8'd170, 8'd85},
        {8'd99,  8'd17},  {8'd128, 8'd128}, {8'd7,   8'd9},   {8'd54,  8'd201}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  x_in = '0;
    logic [W-1:0]  y_in = '0;
    logic [PW-1:0] product;
    logic          done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    shift_add_mult #(.W(W)) u0 (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .x_in    (x_in),
        .y_in    (y_in),
        .product (product),
        .done    (done)
    );

    task automatic chk(input bit ok, input string tag,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_lat(input logic [W-1:0] y);
        int k;
        k = -1;
        for (int i = 0; i < W; i++) if (y[i]) k = i;
        return (k < 0) ? 2 : 2 * (k + 1) + 2;
    endfunction

    // start a run, scramble operands afterward (R8), measure latency
    task automatic run(input logic [W-1:0] x, input logic [W-1:0] y,
                       input bit hold, output int lat, output logic [PW-1:0] res);
        @(negedge clk);
        x_in = x; y_in = y; start = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        x_in = ~x; y_in = ~y;
        if (!hold) start = 1'b0;
        while (!done && lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        res = product;
    endtask

    initial begin
        int lat;
        logic [PW-1:0] res;
        logic [PW-1:0] ref_p;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(product == '0, "R1 product after reset", product, 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            logic [W-1:0] xv;
            logic [W-1:0] yv;
            xv = VEC[v][2*W-1:W];
            yv = VEC[v][W-1:0];
            ref_p = PW'(xv) * PW'(yv);
            run(xv, yv, 1'b0, lat, res);
            chk(res == ref_p, "R4 product", res, ref_p);
            chk(lat == exp_lat(yv), "R5 latency", lat, exp_lat(yv));
            if (xv == 0 || yv == 0)
                chk(res == '0, "R9 zero operand", res, 0);
            if (xv == 8'd255 && yv == 8'd255)
                chk(res == 16'd65025, "R9 all ones", res, 65025);
            if (xv == 8'd9 && yv == 8'd5) begin
                chk(lat == 8, "R6 latency 9x5", lat, 8);
                chk(res == 16'd45, "R6 product 9x5", res, 45);
            end
            @(negedge clk);
            chk(done == 1'b0, "R7 single result", done, 0);
            @(negedge clk);
            chk(product == '0, "R2 idle product", product, 0);
            chk(done == 1'b0, "R2 idle done", done, 0);
        end

        // R3/R7: hold start high across the result
        run(8'd23, 8'd11, 1'b1, lat, res);
        chk(res == 16'd253, "R3 held run product", res, 253);
        repeat (3) begin
            @(negedge clk);
            chk(done == 1'b1, "R7 done holds", done, 1);
            chk(product == 16'd253, "R7 product holds", product, 253);
        end
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R7 done release", done, 0);

        // R8: operand change only while running, result from start edge
        run(8'd3, 8'd200, 1'b0, lat, res);
        chk(res == 16'd600, "R8 operands ignored after start", res, 600);

        // R1: reset in the middle of a run
        @(negedge clk);
        x_in = 8'd77; y_in = 8'd255; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(done == 1'b0, "R1 mid-run reset done", done, 0);
        chk(product == '0, "R1 mid-run reset product", product, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule